// File: doc/BRIEF.md
# Serial Audio Link Frame Deframer

This block watches the controller side of a full-duplex serial audio link. A frame marker line and one serial data line per direction are sampled once per bit time. The block finds the start of each frame from the marker and cuts the frame into slots. Each finished slot is presented as a parallel word. Both directions are handled side by side and share one frame timer.

A frame has 256 bits. A 16-bit tag slot comes first, then twelve slots of 20 bits each, and every slot is sent most significant bit first. The tag carries a ready flag and a twelve-bit mask that says which of the twelve following slots hold data. For every completed slot the block pulses a done strobe for one cycle. Along with it come the slot number, the slot word, a valid flag decoded from the tag of the same frame and, for the audio slots, the top sixteen bits of the word as a sample.

The block's clock `clk` is the inverted bit clock. Each rising edge of `clk` is therefore a falling edge of the bit clock, which is where the link's data is stable. Reset is synchronous and active high. Either direction can be removed at elaboration time.

Top module: `tdm_slot_deframer`

## Requirements
- R1: At each rising edge of `clk` the block samples `sync_i`, `sdo_i` and `sdi_i`. When the `sync_i` samples from the two previous edges are 0 (older) and then 1, the bit sampled at the current edge is bit 0 of a new frame.
- R2: A frame is cut into slot 0 (16 bits) and slots 1 to 12 (20 bits each), MSB first. One cycle after the edge that samples the last bit of a slot, `*_done` is high for exactly one cycle and `*_idx` holds the slot number.
- R3: The slot 0 word appears in `*_data[15:0]` with `*_data[19:16]` zero. The ready flag is `*_data[15]`.
- R4: The tag bits 14 down to 3 form the valid mask: bit 14 belongs to slot 1 and bit 3 to slot 12. Slot k (1..12) is reported with `*_valid` equal to its mask bit from the same frame's tag. Slot 0 is always reported valid.
- R5: For slots 3 to 11, `*_sample` equals `*_data[19:4]`. For slots 0, 1, 2 and 12 it is zero.
- R6: The controller-to-codec lane (`tx_*`) and the codec-to-controller lane (`rx_*`) are decoded in parallel. Their done strobes occur in the same cycles.
- R7: Bits that arrive after bit 255 of a frame and before the next detected frame start produce no done strobe.
- R8: A frame start detected before all 256 bits of the current frame have arrived sets `frame_err`, which then stays set until reset. Back-to-back complete frames do not set it.
- R9: A frame start that cuts short a frame restarts slot counting at slot 0, and the new frame's slots are reported correctly.
- R10: A lane whose enable parameter is 0 holds all its outputs at zero. The other lane keeps working.
- R11: While `rst` is high and right after it, all done strobes, words and `frame_err` are zero and no frame is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Inverted bit clock; rising edge samples the link |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame marker line |
| sdo_i | input | 1 | Serial data, controller to codec |
| sdi_i | input | 1 | Serial data, codec to controller |
| tx_done | output | 1 | One-cycle strobe: a controller-to-codec slot finished |
| tx_idx | output | 4 | Slot number of the finished slot |
| tx_data | output | 20 | Slot word (slot 0 zero-extended) |
| tx_valid | output | 1 | Slot marked valid by the frame's tag |
| tx_sample | output | 16 | Truncated audio sample or zero |
| rx_done | output | 1 | One-cycle strobe: a codec-to-controller slot finished |
| rx_idx | output | 4 | Slot number of the finished slot |
| rx_data | output | 20 | Slot word (slot 0 zero-extended) |
| rx_valid | output | 1 | Slot marked valid by the frame's tag |
| rx_sample | output | 16 | Truncated audio sample or zero |
| frame_err | output | 1 | Sticky flag: frame restarted before it was complete |

## Verification
A slot's results appear one cycle after the edge that samples its last bit, and `frame_err` rises one cycle after the edge that detects an early start. Stimulus is changed on the falling edge of `clk`. A monitor records every done strobe on the falling edge, which is half a cycle after the outputs settle. Each record is then compared against slot words, masks and samples that the bench computes itself. Ignored trailing bits and the disabled lane are judged by counting strobes over a window that ends at least one full cycle after the last stimulus bit.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
    localparam int TAG_W   = 16;
    localparam int SLOT_W  = 20;
    localparam int NSLOT   = 13;
    localparam int SMP_W   = 16;
    localparam int IDX_W   = 4;
    localparam int MASK_W  = NSLOT - 1;
    localparam int LEN_W   = 5;
    localparam int AUD_LO  = 3;
    localparam int AUD_HI  = 11;

    typedef logic [IDX_W-1:0]  slot_idx_t;
    typedef logic [SLOT_W-1:0] slot_word_t;

    // where the bit sampled at this edge sits in the frame
    typedef struct packed {
        logic      start;
        logic      take;
        logic      first;
        logic      last;
        slot_idx_t slot;
    } bit_pos_t;

    // one completed slot as handed out by a lane
    typedef struct packed {
        logic             done;
        slot_idx_t        idx;
        slot_word_t       data;
        logic             valid;
        logic [SMP_W-1:0] sample;
    } slot_rec_t;

    function automatic logic [LEN_W-1:0] slot_len(slot_idx_t s);
        return (s == '0) ? LEN_W'(TAG_W) : LEN_W'(SLOT_W);
    endfunction

    function automatic logic carries_audio(slot_idx_t s);
        return (int'(s) >= AUD_LO) && (int'(s) <= AUD_HI);
    endfunction
endpackage

// File: rtl/dfr_frame_timer.sv
module dfr_frame_timer
    import dfr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_i,
    output bit_pos_t pos,
    output logic     overrun
);
    logic             sync_q1, sync_q2;
    logic             open_q;
    logic             overrun_q;
    slot_idx_t        slot_q;
    logic [LEN_W-1:0] sbit_q;

    logic             start_c, take_c, last_c;
    slot_idx_t        slot_c;
    logic [LEN_W-1:0] sbit_c;

    always_comb begin
        start_c = sync_q1 & ~sync_q2;
        take_c  = start_c | open_q;
        slot_c  = start_c ? '0 : slot_q;
        sbit_c  = start_c ? '0 : sbit_q;
        last_c  = take_c && (sbit_c == slot_len(slot_c) - LEN_W'(1));
        pos.start = start_c;
        pos.take  = take_c;
        pos.first = take_c && (sbit_c == '0);
        pos.last  = last_c;
        pos.slot  = slot_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q1   <= 1'b0;
            sync_q2   <= 1'b0;
            open_q    <= 1'b0;
            overrun_q <= 1'b0;
            slot_q    <= '0;
            sbit_q    <= '0;
        end else begin
            sync_q1 <= sync_i;
            sync_q2 <= sync_q1;
            if (take_c) begin
                if (last_c) begin
                    sbit_q <= '0;
                    slot_q <= slot_c + slot_idx_t'(1);
                    open_q <= (int'(slot_c) != NSLOT - 1);
                end else begin
                    sbit_q <= sbit_c + LEN_W'(1);
                    slot_q <= slot_c;
                    open_q <= 1'b1;
                end
            end
            if (start_c && open_q) overrun_q <= 1'b1;
        end
    end

    assign overrun = overrun_q;

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        open_q |-> (int'(slot_q) < NSLOT)); // R2
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        start_c |=> (slot_q == '0 && sbit_q == LEN_W'(1) && open_q)); // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun_q |=> overrun_q); // R8
endmodule

// File: rtl/dfr_lane.sv
module dfr_lane
    import dfr_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  bit_pos_t  pos,
    input  logic      sd_i,
    output slot_rec_t rec
);
    generate
        if (ENABLE) begin : g_on
            slot_word_t        sh_q, word_c;
            logic [MASK_W-1:0] mask_q, mask_shl;
            logic              valid_c;
            slot_rec_t         rec_q;

            always_comb begin
                word_c   = pos.first ? {{(SLOT_W-1){1'b0}}, sd_i}
                                     : {sh_q[SLOT_W-2:0], sd_i};
                mask_shl = mask_q << (pos.slot - slot_idx_t'(1));
                valid_c  = (pos.slot == '0) | mask_shl[MASK_W-1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q   <= '0;
                    mask_q <= '0;
                    rec_q  <= '0;
                end else begin
                    rec_q.done <= pos.take & pos.last;
                    if (pos.take) sh_q <= word_c;
                    if (pos.take && pos.last) begin
                        rec_q.idx    <= pos.slot;
                        rec_q.data   <= word_c;
                        rec_q.valid  <= valid_c;
                        rec_q.sample <= carries_audio(pos.slot) ? word_c[SLOT_W-1 -: SMP_W] : '0;
                        if (pos.slot == '0) mask_q <= word_c[TAG_W-2 -: MASK_W];
                    end
                end
            end

            assign rec = rec_q;

            AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
                rec_q.done |=> !rec_q.done); // R2
            AST_TAG_ZEXT: assert property (@(posedge clk) disable iff (rst)
                (rec_q.done && rec_q.idx == '0) |-> (rec_q.data[SLOT_W-1:TAG_W] == '0 && rec_q.valid)); // R3
            AST_SAMPLE_NONAUDIO: assert property (@(posedge clk) disable iff (rst)
                (rec_q.done && !carries_audio(rec_q.idx)) |-> (rec_q.sample == '0)); // R5
        end else begin : g_off
            assign rec = '0;
        end
    endgenerate
endmodule

// File: rtl/tdm_slot_deframer.sv
module tdm_slot_deframer
    import dfr_pkg::*;
#(
    parameter bit TX_EN = 1'b1,
    parameter bit RX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    input  logic              sdo_i,
    input  logic              sdi_i,
    output logic              tx_done,
    output logic [IDX_W-1:0]  tx_idx,
    output logic [SLOT_W-1:0] tx_data,
    output logic              tx_valid,
    output logic [SMP_W-1:0]  tx_sample,
    output logic              rx_done,
    output logic [IDX_W-1:0]  rx_idx,
    output logic [SLOT_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [SMP_W-1:0]  rx_sample,
    output logic              frame_err
);
    bit_pos_t  pos;
    slot_rec_t tx_rec, rx_rec;

    dfr_frame_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (sync_i),
        .pos     (pos),
        .overrun (frame_err)
    );

    dfr_lane #(.ENABLE(TX_EN)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .pos  (pos),
        .sd_i (sdo_i),
        .rec  (tx_rec)
    );

    dfr_lane #(.ENABLE(RX_EN)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .pos  (pos),
        .sd_i (sdi_i),
        .rec  (rx_rec)
    );

    assign tx_done   = tx_rec.done;
    assign tx_idx    = tx_rec.idx;
    assign tx_data   = tx_rec.data;
    assign tx_valid  = tx_rec.valid;
    assign tx_sample = tx_rec.sample;
    assign rx_done   = rx_rec.done;
    assign rx_idx    = rx_rec.idx;
    assign rx_data   = rx_rec.data;
    assign rx_valid  = rx_rec.valid;
    assign rx_sample = rx_rec.sample;

    generate
        if (TX_EN && RX_EN) begin : g_pair
            AST_LANES_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
                (tx_done == rx_done) && (tx_idx == rx_idx)); // R6
        end
    endgenerate
endmodule

// File: tb/tdm_slot_deframer_tb.sv
module tdm_slot_deframer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 6;
    localparam int LOGN       = 256;
    // [31] ready flag, [27:16] valid mask, [15:0] data seed
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        32'h8FFF_1234, 32'h0000_BEEF, 32'h8800_0F0F,
        32'h0001_7A5C, 32'h8AAA_C3C3, 32'h0555_0001
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_i = 1'b0, sdo = 1'b0, sdi = 1'b0;

    logic        tx_done, rx_done, frame_err;
    logic [3:0]  tx_idx, rx_idx;
    logic [19:0] tx_data, rx_data;
    logic        tx_valid, rx_valid;
    logic [15:0] tx_sample, rx_sample;

    logic        nr_tx_done, nr_rx_done, nr_err;
    logic [3:0]  nr_tx_idx, nr_rx_idx;
    logic [19:0] nr_tx_data, nr_rx_data;
    logic        nr_tx_valid, nr_rx_valid;
    logic [15:0] nr_tx_sample, nr_rx_sample;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_deframer dut_i (
        .clk(clk), .rst(rst), .sync_i(sync_i), .sdo_i(sdo), .sdi_i(sdi),
        .tx_done(tx_done), .tx_idx(tx_idx), .tx_data(tx_data), .tx_valid(tx_valid), .tx_sample(tx_sample),
        .rx_done(rx_done), .rx_idx(rx_idx), .rx_data(rx_data), .rx_valid(rx_valid), .rx_sample(rx_sample),
        .frame_err(frame_err)
    );

    tdm_slot_deframer #(.TX_EN(1'b1), .RX_EN(1'b0)) dut_nr (
        .clk(clk), .rst(rst), .sync_i(sync_i), .sdo_i(sdo), .sdi_i(sdi),
        .tx_done(nr_tx_done), .tx_idx(nr_tx_idx), .tx_data(nr_tx_data), .tx_valid(nr_tx_valid), .tx_sample(nr_tx_sample),
        .rx_done(nr_rx_done), .rx_idx(nr_rx_idx), .rx_data(nr_rx_data), .rx_valid(nr_rx_valid), .rx_sample(nr_rx_sample),
        .frame_err(nr_err)
    );

    int n_chk = 0, n_fail = 0;
    int tx_n = 0, rx_n = 0, nr_tx_hits = 0, nr_rx_hits = 0, nr_rx_nonzero = 0;
    logic [3:0]  tx_idx_l [0:LOGN-1];
    logic [19:0] tx_dat_l [0:LOGN-1];
    logic        tx_val_l [0:LOGN-1];
    logic [15:0] tx_smp_l [0:LOGN-1];
    logic [3:0]  rx_idx_l [0:LOGN-1];
    logic [19:0] rx_dat_l [0:LOGN-1];
    logic        rx_val_l [0:LOGN-1];
    logic [15:0] rx_smp_l [0:LOGN-1];

    // record every strobe half a cycle after the outputs settle
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_done) begin
                if (tx_n < LOGN) begin
                    tx_idx_l[tx_n] = tx_idx; tx_dat_l[tx_n] = tx_data;
                    tx_val_l[tx_n] = tx_valid; tx_smp_l[tx_n] = tx_sample;
                end
                tx_n++;
            end
            if (rx_done) begin
                if (rx_n < LOGN) begin
                    rx_idx_l[rx_n] = rx_idx; rx_dat_l[rx_n] = rx_data;
                    rx_val_l[rx_n] = rx_valid; rx_smp_l[rx_n] = rx_sample;
                end
                rx_n++;
            end
            if (nr_tx_done) nr_tx_hits++;
            if (nr_rx_done) nr_rx_hits++;
            if (nr_rx_data != 20'h0 || nr_rx_sample != 16'h0 || nr_rx_valid) nr_rx_nonzero++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mask_of(logic [31:0] v, bit rx);
        return rx ? ~v[27:16] : v[27:16];
    endfunction

    function automatic logic [19:0] mkword(logic [31:0] v, int k, bit rx);
        logic [15:0] s;
        s = v[15:0] ^ (rx ? 16'h5AA5 : 16'h0000);
        if (k == 0) return {4'h0, v[31], mask_of(v, rx), 3'b000};
        return {s, s[3:0]} ^ (20'(k) * 20'h0B5A3);
    endfunction

    function automatic logic frame_bit(logic [31:0] v, int b, bit rx);
        int k, off, len;
        logic [19:0] w;
        if (b < 16) begin k = 0; off = b; len = 16; end
        else begin k = (b - 16) / 20 + 1; off = (b - 16) % 20; len = 20; end
        w = mkword(v, k, rx);
        return w[len - 1 - off];
    endfunction

    task automatic send_bit(input logic s, input logic o, input logic i);
        @(negedge clk);
        sync_i = s; sdo = o; sdi = i;
    endtask

    task automatic prelude();
        send_bit(1'b0, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
    endtask

    task automatic send_frame(input logic [31:0] v, input int nbits, input bit chain);
        for (int b = 0; b < nbits; b++)
            send_bit((b < 15) || (chain && b == nbits - 1), frame_bit(v, b, 1'b0), frame_bit(v, b, 1'b1));
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) send_bit(1'b0, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    // compare the 13 records starting at bt / br against the computed frame
    task automatic check_frame(input logic [31:0] v, input int bt, input int br);
        for (int k = 0; k < 13; k++) begin
            logic [19:0] wt, wr;
            logic [11:0] mt, mr;
            wt = mkword(v, k, 1'b0); wr = mkword(v, k, 1'b1);
            mt = mask_of(v, 1'b0);   mr = mask_of(v, 1'b1);
            chk("R2", "tx slot index", 32'(tx_idx_l[bt+k]), 32'(k));
            chk(k == 0 ? "R3" : "R2", "tx slot word", 32'(tx_dat_l[bt+k]), 32'(wt));
            chk("R4", "tx valid", 32'(tx_val_l[bt+k]), 32'(k == 0 ? 1'b1 : mt[12-k]));
            chk("R5", "tx sample", 32'(tx_smp_l[bt+k]), 32'((k >= 3 && k <= 11) ? wt[19:4] : 16'h0));
            chk("R6", "rx slot index", 32'(rx_idx_l[br+k]), 32'(k));
            chk("R6", "rx slot word", 32'(rx_dat_l[br+k]), 32'(wr));
            chk("R4", "rx valid", 32'(rx_val_l[br+k]), 32'(k == 0 ? 1'b1 : mr[12-k]));
            chk("R5", "rx sample", 32'(rx_smp_l[br+k]), 32'((k >= 3 && k <= 11) ? wr[19:4] : 16'h0));
        end
    endtask

    task automatic run_all();
        int bt, br;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11", "done during reset", 32'({tx_done, rx_done}), 32'h0);
        chk("R11", "err during reset", 32'(frame_err), 32'h0);
        rst = 1'b0;
        idle(4);
        chk("R11", "data after reset", 32'(tx_data), 32'h0);
        chk("R11", "no strobe from idle link", 32'(tx_n + rx_n), 32'h0);

        // R1 R2 R4 R5 R6: table of frames
        for (int vi = 0; vi < NVEC; vi++) begin
            bt = tx_n; br = rx_n;
            prelude();
            send_frame(VEC[vi], 256, 1'b0);
            idle(2);
            chk("R1", "tx slots per frame", 32'(tx_n - bt), 32'd13);
            chk("R6", "rx slots per frame", 32'(rx_n - br), 32'd13);
            check_frame(VEC[vi], bt, br);
        end
        chk("R8", "no error on clean frames", 32'(frame_err), 32'h0);

        // R7: trailing bits after bit 255 are ignored
        bt = tx_n; br = rx_n;
        for (int j = 0; j < 60; j++) send_bit(1'b0, j[0], ~j[1]);
        idle(2);
        chk("R7", "tx strobes on trailing bits", 32'(tx_n - bt), 32'h0);
        chk("R7", "rx strobes on trailing bits", 32'(rx_n - br), 32'h0);

        // R8: back-to-back frames are not an overrun
        bt = tx_n; br = rx_n;
        prelude();
        send_frame(VEC[4], 256, 1'b1);
        send_frame(VEC[5], 256, 1'b0);
        idle(2);
        chk("R2", "slots over two chained frames", 32'(tx_n - bt), 32'd26);
        check_frame(VEC[4], bt, br);
        check_frame(VEC[5], bt + 13, br + 13);
        chk("R8", "no error on chained frames", 32'(frame_err), 32'h0);

        // R8 R9: frame cut short after 100 bits
        bt = tx_n;
        prelude();
        send_frame(VEC[3], 100, 1'b0);
        send_bit(1'b1, 1'b1, 1'b1);
        chk("R2", "slots from cut frame", 32'(tx_n - bt), 32'd5);
        chk("R8", "error before early start", 32'(frame_err), 32'h0);
        bt = tx_n; br = rx_n;
        send_frame(VEC[2], 256, 1'b0);
        idle(2);
        chk("R8", "error after early start", 32'(frame_err), 32'h1);
        chk("R9", "slots after restart", 32'(tx_n - bt), 32'd13);
        check_frame(VEC[2], bt, br);
        idle(20);
        chk("R8", "error stays set", 32'(frame_err), 32'h1);

        // R10: lane removed by parameter
        chk("R10", "disabled lane strobes", 32'(nr_rx_hits), 32'h0);
        chk("R10", "disabled lane outputs", 32'(nr_rx_nonzero), 32'h0);
        chk("R10", "enabled lane beside it", 32'(nr_tx_hits), 32'(tx_n));

        // R11: reset clears the sticky error
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "error cleared by reset", 32'(frame_err), 32'h0);
        chk("R11", "done cleared by reset", 32'({tx_done, rx_done}), 32'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule